// File: doc/BRIEF.md
# Seconds Real-Time Clock with Masked Interrupt Groups

This peripheral keeps a 32-bit count of whole seconds behind a simple 32-bit register bus. A prescaler divides the bus clock by a parameterised number of cycles per second. Each time it wraps, the seconds count steps by one, a tick event is recorded and the new count is compared with a programmable alarm value. Software loads the count through a set-time register; the loaded value becomes the offset from which later seconds accumulate.

Two event groups share the register map. The clock group records tick and alarm events. The bus-fault group records accesses to unmapped or misaligned offsets. Each group has a write-1-to-clear status register, a mask that can be changed only through a pair of enable/disable alias registers, and its own interrupt line. A line is high while any status bit is set whose mask bit is clear.

Top module: `sec_rtc_top`

## Requirements
- R1: `rst_ni` resets asynchronously and is released through two clock edges. After reset the count, alarm and both status registers read 0, both masks read all ones, and both interrupt lines are low.
- R2: The count increases by exactly one every TICKS_PER_SEC cycles, and at no other time.
- R3: A write to set-time (0x00) loads the count and restarts the prescaler. Reads of set-time and of current-time (0x04) return the live count. The first step after the write shows the written value plus one, TICKS_PER_SEC cycles later.
- R4: Clock status (0x0C) is write-1-to-clear. Bit 0 sets on every second step. Bit 1 sets on a step whose new count equals the alarm (0x08, read/write). When a set and a clear fall in the same cycle, the set wins. Bits written as 0 are unchanged.
- R5: Writing clock-enable (0x14) clears the mask bits written as 1. Writing clock-disable (0x18) sets them. All other mask bits keep their value. A write to the mask register (0x10) has no effect.
- R6: `rtc_irq` equals the OR over the clock status bits ANDed with the inverse of the mask. It follows any register change by one cycle.
- R7: Any full-width access to an unmapped offset (0x2C and above) or to a misaligned one (address bits 1:0 not 0) sets bit 0 of the bus-fault status (0x1C). Such a read returns 0.
- R8: The bus-fault group has its own mask (0x20), enable alias (0x24) and disable alias (0x28). They behave as in R5. The bus-fault status is write-1-to-clear, and `aerr_irq` equals status AND NOT mask.
- R9: An access whose byte enables are not all ones is ignored. It changes no register, reads 0 and records no bus fault.
- R10: The four alias registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| rtc_irq | output | 1 | Clock group interrupt |
| aerr_irq | output | 1 | Bus-fault group interrupt |

## Verification
The embedded assertions check properties on every cycle:
- prescaler range and wrap, and the one-step advance of the count;
- the load value after a set-time write;
- mask bits changing only through the alias writes, in the right direction;
- status bits staying set until a clearing write;
- a bus fault being recorded after a bad access.

Other behaviour needs the bench's scenarios, which compare a behavioural model on every clock:
- the alarm firing only on the step that reaches the alarm value;
- set-beats-clear ordering;
- partial-width accesses being ignored;
- the alias and unmapped offsets reading 0.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [3:0] {
    RS_SETTIME, RS_NOW, RS_ALARM, RS_ISTAT, RS_IMASK, RS_IEN, RS_IDIS,
    RS_AERR, RS_AMASK, RS_AEN, RS_ADIS, RS_NONE
  } reg_sel_e;

  localparam int unsigned RTC_EV_W  = 2;
  localparam int unsigned AERR_EV_W = 1;

  function automatic reg_sel_e decode_addr(input logic [7:0] a);
    reg_sel_e r;
    if (a[1:0] != 2'b00) r = RS_NONE;
    else begin
      case (a[7:2])
        6'd0:    r = RS_SETTIME;
        6'd1:    r = RS_NOW;
        6'd2:    r = RS_ALARM;
        6'd3:    r = RS_ISTAT;
        6'd4:    r = RS_IMASK;
        6'd5:    r = RS_IEN;
        6'd6:    r = RS_IDIS;
        6'd7:    r = RS_AERR;
        6'd8:    r = RS_AMASK;
        6'd9:    r = RS_AEN;
        6'd10:   r = RS_ADIS;
        default: r = RS_NONE;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic q1, q2;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign rst_sync_no = q2;
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = $clog2(TICKS_PER_SEC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap   = (cnt_q == LAST);
  assign tick_o = wrap && !clr_i;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (clr_i || wrap) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R2: the prescaler never leaves its range and restarts after a step
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r2_tick_wrap: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_irq_group.sv
module rtc_irq_group #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         w1c_i,
  input  logic         en_i,
  input  logic         dis_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] status_q, status_d, mask_q, mask_d;

  always_comb begin
    status_d = status_q;
    if (w1c_i) status_d = status_q & ~wdata_i;
    status_d = status_d | set_i;
  end

  always_comb begin
    mask_d = mask_q;
    if (en_i)       mask_d = mask_q & ~wdata_i;
    else if (dis_i) mask_d = mask_q | wdata_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);

  // R5 / R8: the mask moves only through the aliases, in their direction
  a_r5_en_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    en_i |=> ((mask_q & $past(wdata_i)) == '0));
  a_r5_dis_sets: assert property (@(posedge clk) disable iff (!rst_ni)
    (dis_i && !en_i) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (!en_i && !dis_i) |=> $stable(mask_q));
  // R4 / R8: a status bit stays set until a clearing write
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    !w1c_i |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/sec_rtc_top.sv
module sec_rtc_top
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned ADDR_W        = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rtc_irq,
  output logic              aerr_irq
);
  logic        rst_n;
  logic        full, wr_ok, rd_ok, bad_acc, load, tick, alarm_hit;
  reg_sel_e    sel;
  logic [31:0] secs_q, secs_d, alarm_q, alarm_d;
  logic [RTC_EV_W-1:0]  rtc_stat, rtc_mask;
  logic [AERR_EV_W-1:0] aerr_stat, aerr_mask;

  rtc_rst_sync i_rst (.clk(clk), .rst_ni(rst_ni), .rst_sync_no(rst_n));

  always_comb begin
    full    = bus_sel && (bus_be == 4'hF);
    sel     = decode_addr(8'(bus_addr));
    if ((ADDR_W > 8) && ((bus_addr >> 8) != '0)) sel = RS_NONE;
    wr_ok   = full && bus_wr;
    rd_ok   = full && !bus_wr;
    bad_acc = full && (sel == RS_NONE);
    load    = wr_ok && (sel == RS_SETTIME);
  end

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_pre (
    .clk(clk), .rst_ni(rst_n), .clr_i(load), .tick_o(tick));

  assign alarm_hit = tick && ((secs_q + 32'd1) == alarm_q);

  always_comb begin
    secs_d  = secs_q;
    alarm_d = alarm_q;
    if (load)      secs_d = bus_wdata;
    else if (tick) secs_d = secs_q + 32'd1;
    if (wr_ok && (sel == RS_ALARM)) alarm_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q  <= '0;
      alarm_q <= '0;
    end else begin
      secs_q  <= secs_d;
      alarm_q <= alarm_d;
    end
  end

  rtc_irq_group #(.W(RTC_EV_W)) i_rtc_grp (
    .clk(clk), .rst_ni(rst_n),
    .set_i({alarm_hit, tick}),
    .w1c_i(wr_ok && (sel == RS_ISTAT)),
    .en_i(wr_ok && (sel == RS_IEN)),
    .dis_i(wr_ok && (sel == RS_IDIS)),
    .wdata_i(bus_wdata[RTC_EV_W-1:0]),
    .status_o(rtc_stat), .mask_o(rtc_mask), .irq_o(rtc_irq));

  rtc_irq_group #(.W(AERR_EV_W)) i_aerr_grp (
    .clk(clk), .rst_ni(rst_n),
    .set_i(AERR_EV_W'(bad_acc)),
    .w1c_i(wr_ok && (sel == RS_AERR)),
    .en_i(wr_ok && (sel == RS_AEN)),
    .dis_i(wr_ok && (sel == RS_ADIS)),
    .wdata_i(bus_wdata[AERR_EV_W-1:0]),
    .status_o(aerr_stat), .mask_o(aerr_mask), .irq_o(aerr_irq));

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      case (sel)
        RS_SETTIME, RS_NOW: bus_rdata = secs_q;
        RS_ALARM:           bus_rdata = alarm_q;
        RS_ISTAT:           bus_rdata = 32'(rtc_stat);
        RS_IMASK:           bus_rdata = 32'(rtc_mask);
        RS_AERR:            bus_rdata = 32'(aerr_stat);
        RS_AMASK:           bus_rdata = 32'(aerr_mask);
        default:            bus_rdata = '0;
      endcase
    end
  end

  // R3: a set-time write lands in the count
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (secs_q == $past(bus_wdata)));
  // R2: a step without load advances the count by exactly one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (secs_q == $past(secs_q) + 32'd1));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(secs_q));
  // R7: a bad access is recorded
  a_r7_aerr: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> aerr_stat[0]);
endmodule

// File: tb/test_sec_rtc_top.sv
module test_sec_rtc_top;
  localparam int TPS = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rtc_irq, aerr_irq;

  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  sec_rtc_top #(.TICKS_PER_SEC(TPS), .ADDR_W(8)) i_sec_rtc_top (
    .clk(clk), .rst_ni(rst_ni), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rtc_irq(rtc_irq), .aerr_irq(aerr_irq));

  // behavioural reference model
  int          m_rst_cnt = 0;
  int          m_pre = 0;
  logic [31:0] m_secs = 0, m_alarm = 0;
  logic [1:0]  m_stat = 0, m_mask = 2'b11;
  logic        m_aerr = 0, m_amask = 1'b1;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a[1:0] != 0) return 0;
    case (a)
      8'h00, 8'h04: return m_secs;
      8'h08: return m_alarm;
      8'h0C: return 32'(m_stat);
      8'h10: return 32'(m_mask);
      8'h1C: return 32'(m_aerr);
      8'h20: return 32'(m_amask);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rst_cnt = 0; m_pre = 0; m_secs = 0; m_alarm = 0;
      m_stat = 0; m_mask = 2'b11; m_aerr = 0; m_amask = 1;
    end else if (m_rst_cnt < 2) begin
      m_rst_cnt++;
    end else begin
      logic        ok, ld, tk;
      logic [31:0] old_alarm;
      logic [1:0]  set;
      ok = bus_sel && bus_be == 4'hF;
      ld = ok && bus_wr && bus_addr == 8'h00;
      old_alarm = m_alarm;
      tk = (m_pre == TPS - 1) && !ld;
      set = 0;
      if (ld || m_pre == TPS - 1) m_pre = 0; else m_pre++;
      if (tk) begin
        set[0] = 1;
        if (m_secs + 1 == old_alarm) set[1] = 1;
        m_secs = m_secs + 1;
      end
      if (ld) m_secs = bus_wdata;
      if (ok && bus_wr) begin
        case (bus_addr)
          8'h08: m_alarm = bus_wdata;
          8'h0C: m_stat = m_stat & ~bus_wdata[1:0];
          8'h14: m_mask = m_mask & ~bus_wdata[1:0];
          8'h18: m_mask = m_mask | bus_wdata[1:0];
          8'h1C: if (bus_wdata[0]) m_aerr = 0;
          8'h24: if (bus_wdata[0]) m_amask = 0;
          8'h28: if (bus_wdata[0]) m_amask = 1;
          default: ;
        endcase
      end
      m_stat = m_stat | set;
      if (ok && (bus_addr[1:0] != 0 || bus_addr >= 8'h2C)) m_aerr = 1;
    end
  end

  function automatic void chk(input string req, input logic [31:0] got,
                              input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endfunction

  // every-clock comparison of both interrupt lines (R6, R8)
  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R6 rtc_irq", 32'(rtc_irq), 32'(|(m_stat & ~m_mask)));
      chk("R8 aerr_irq", 32'(aerr_irq), 32'(m_aerr & ~m_amask));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a,
                    input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = be;
    #1;
    chk(req, bus_rdata, (be == 4'hF) ? m_read(a) : 32'd0);
    @(negedge clk);
    bus_sel = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1;
    idle(1);
    // R1: reset values
    rd("R1 count", 8'h04); rd("R1 alarm", 8'h08); rd("R1 istat", 8'h0C);
    rd("R1 imask", 8'h10); rd("R1 aerr", 8'h1C); rd("R1 amask", 8'h20);
    chk("R1 count zero", m_read(8'h04) > 1 ? 32'd1 : 32'd0, 32'd0);
    chk("R1 mask ones", 32'(m_mask), 32'd3);
    // R10: aliases read zero
    rd("R10 ien", 8'h14); rd("R10 idis", 8'h18);
    rd("R10 aen", 8'h24); rd("R10 adis", 8'h28);
    // R2: stepping
    idle(3 * TPS);
    rd("R2 count", 8'h04);
    // R3: set-time load, live readback on both offsets
    wr(8'h00, 32'd1000);
    rd("R3 settime", 8'h00); rd("R3 now", 8'h04);
    idle(TPS);
    rd("R3 plus one", 8'h04);
    // R5: enable/disable aliases, direct mask write ignored
    wr(8'h10, 32'h0);
    rd("R5 mask direct", 8'h10);
    wr(8'h14, 32'h1);
    rd("R5 enable bit0", 8'h10);
    idle(2 * TPS);
    rd("R6 istat", 8'h0C);
    wr(8'h0C, 32'h0);
    rd("R4 w1c zero", 8'h0C);
    wr(8'h0C, 32'h3);
    rd("R4 w1c", 8'h0C);
    wr(8'h18, 32'h1);
    rd("R5 disable", 8'h10);
    // R4: alarm
    wr(8'h00, 32'd500);
    wr(8'h08, 32'd503);
    wr(8'h0C, 32'h3);
    wr(8'h14, 32'h2);
    idle(2 * TPS);
    rd("R4 alarm early", 8'h0C);
    idle(2 * TPS);
    rd("R4 alarm set", 8'h0C);
    wr(8'h0C, 32'h2);
    rd("R4 alarm clr", 8'h0C);
    // R4: clear and step in the same cycle (set wins)
    for (int k = 0; k < TPS; k++) wr(8'h0C, 32'h1);
    rd("R4 set wins", 8'h0C);
    // R9: partial accesses ignored
    wr(8'h08, 32'hFFFF_FFFF, 4'h3);
    rd("R9 alarm kept", 8'h08);
    rd("R9 partial read", 8'h04, 4'h1);
    wr(8'h80, 32'h1, 4'h7);
    rd("R9 no fault", 8'h1C);
    // R7: unmapped and misaligned accesses
    rd("R7 unmapped read", 8'h40);
    rd("R7 aerr set", 8'h1C);
    wr(8'h1C, 32'h1);
    rd("R7 aerr clr", 8'h1C);
    wr(8'h05, 32'h1234);
    rd("R7 misaligned", 8'h1C);
    // R8: bus-fault group aliases
    wr(8'h24, 32'h1);
    rd("R8 amask en", 8'h20);
    idle(2);
    wr(8'h28, 32'h1);
    rd("R8 amask dis", 8'h20);
    wr(8'h1C, 32'h1);
    rd("R8 aerr clr", 8'h1C);
    // R1: reset in the middle of activity
    rst_ni = 0;
    idle(2);
    rst_ni = 1;
    idle(1);
    rd("R1 re-reset istat", 8'h0C);
    rd("R1 re-reset amask", 8'h20);
    idle(5);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule